// File: doc/BRIEF.md
# Little-Endian External Bus Lane Steering

This block links an internal 32-bit load/store port to an external memory bus. The external bus is either 32 or 16 bits wide, and a static input selects which. Each request is a byte, a word or a longword at a byte offset within a 32-bit word.

For writes, the block moves the data onto the external byte lanes that little-endian ordering calls for. For every cycle, reads and writes alike, it pulls down one active-low strobe per lane that carries data. For reads, it collects the bytes from those lanes into a right-justified result. On the narrow bus a longword becomes two external cycles, lower half first. The two read halves are merged and answered with a single completion pulse.

The internal side uses a valid/ready handshake and accepts a request only while idle. The external side holds each cycle until the memory returns an acknowledge. A request with bad alignment, or with the reserved size code, never reaches the bus and is answered with an error pulse.

Top module: `ext_lane_steer`

## Requirements
- R1: On the 32-bit bus (`bus16`=0), a byte at offset n (0..3) drives only lane n. Lane n is `ext_wdata[8n+7:8n]` and is strobed by `ext_strb_n[n]`. Size codes are 0 byte, 1 word, 2 longword and 3 reserved.
- R2: On the 32-bit bus, a word at offset 0 uses lanes 0 and 1, and a word at offset 2 uses lanes 2 and 3. In both cases the low data byte goes on the lower lane.
- R3: On the 32-bit bus, a longword at offset 0 strobes all four lanes, with data bits 8k+7..8k on lane k.
- R4: On the 16-bit bus (`bus16`=1), a byte at an even offset uses lane 0 and one at an odd offset uses lane 1. `ext_strb_n[3:2]` stay high, and `ext_wdata[31:16]` stays zero.
- R5: On the 16-bit bus, a word at offset 0 or 2 strobes lanes 0 and 1, with the high data byte on lane 1.
- R6: On the 16-bit bus, a longword takes two external cycles. The first is at `ext_offset` 0 and carries bits 15..0. The second is at `ext_offset` 2 and carries bits 31..16. Both lower strobes are low in each cycle.
- R7: Read data is right-justified: a byte in bits 7..0 and a word in bits 15..0, with all other bits zero. Bytes on lanes outside the access are ignored.
- R8: A split longword read returns {second-cycle bits 15..0, first-cycle bits 15..0}, with one `rsp_done` pulse after the second acknowledge only.
- R9: A word at an odd offset, a longword at a nonzero offset, or size 3 raises `rsp_err` for one cycle, the cycle after acceptance. No external cycle and no strobe occur.
- R10: While `ext_req` is low, all strobes are high and `ext_wdata` is zero. `ext_wdata` is also zero on read cycles and on lanes outside the access.
- R11: `req_ready` is high only when idle. A `req_valid` raised while busy, including during either half of a split longword, is ignored.
- R12: `ext_req`, `ext_offset`, the strobes and `ext_wdata` hold steady until `ext_ack`. `rsp_done` rises for one cycle, the cycle after the final acknowledge.
- R13: After reset, `req_ready` is high and `ext_req`, `rsp_done` and `rsp_err` are low, with all strobes high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus16 | input | 1 | 1 selects the 16-bit external bus (static) |
| req_valid | input | 1 | Internal request valid |
| req_ready | output | 1 | Block idle, request can be taken |
| req_write | input | 1 | 1 write, 0 read |
| req_size | input | 2 | 0 byte, 1 word, 2 longword, 3 reserved |
| req_offset | input | 2 | Byte offset within the 32-bit word |
| req_wdata | input | 32 | Right-justified write data |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_err | output | 1 | One-cycle misaligned/reserved pulse |
| rsp_rdata | output | 32 | Right-justified read data, valid with rsp_done |
| ext_req | output | 1 | External cycle in progress |
| ext_ack | input | 1 | External cycle acknowledge |
| ext_write | output | 1 | External cycle direction |
| ext_offset | output | 2 | Byte offset of the current external cycle |
| ext_strb_n | output | 4 | Active-low lane strobes, bit n for lane n |
| ext_wdata | output | 32 | Lane-steered write data |
| ext_rdata | input | 32 | External read data on the lanes |

## Verification
The bench covers every combination of bus width, direction, size and offset, 64 in all. Each case uses random data and random acknowledge delays, and random garbage sits on the unused read lanes. The first corner case is lane selection by offset parity on the narrow bus: a design that reused the wide mapping would strobe lane 2 or 3. The second is the split longword. A design that got it wrong would drop the second half, swap the halves, or pulse completion after the first acknowledge. Misaligned and reserved requests are checked to produce no bus cycle at all, and a request pushed in while busy is checked to leave no trace.

// File: rtl/lsteer_pkg.sv
package lsteer_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_WORD = 2'd1,
    SZ_LONG = 2'd2,
    SZ_RSVD = 2'd3
  } xfer_size_e;

  typedef enum logic {
    ST_IDLE   = 1'b0,
    ST_ACCESS = 1'b1
  } seq_state_e;
endpackage

// File: rtl/lsteer_rst_sync.sv
module lsteer_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sh_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sh_q <= '0;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b1};
  end

  assign rst_sync_n = sh_q[STAGES-1];
endmodule

// File: rtl/lsteer_check.sv
module lsteer_check
  import lsteer_pkg::*;
#(
  parameter int LANES = 4,
  localparam int OW = $clog2(LANES)
) (
  input  logic          bus16,
  input  logic [1:0]    size,
  input  logic [OW-1:0] off,
  output logic          misaligned,
  output logic          split
);
  always_comb begin
    unique case (xfer_size_e'(size))
      SZ_BYTE: misaligned = 1'b0;
      SZ_WORD: misaligned = off[0];
      SZ_LONG: misaligned = |off;
      default: misaligned = 1'b1;
    endcase
    split = bus16 && (xfer_size_e'(size) == SZ_LONG);
  end
endmodule

// File: rtl/lsteer_lanes.sv
module lsteer_lanes #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int DW     = LANES * BYTE_W,
  localparam int OW     = $clog2(LANES),
  localparam int NARROW = LANES / 2
) (
  input  logic             bus16,
  input  logic [1:0]       size,
  input  logic [OW-1:0]    req_off,
  input  logic             half,
  input  logic [DW-1:0]    wdata,
  input  logic [DW-1:0]    lane_rdata,
  output logic [OW-1:0]    ext_off,
  output logic [LANES-1:0] lane_en,
  output logic [DW-1:0]    lane_wdata,
  output logic [DW-1:0]    gathered
);
  int bus_bytes;
  int req_bytes;
  int cyc_bytes;
  int src_base;
  int lane_base;

  // Window of lanes touched in this external cycle
  always_comb begin
    bus_bytes = bus16 ? NARROW : LANES;
    req_bytes = 1 << int'(size);
    cyc_bytes = (req_bytes < bus_bytes) ? req_bytes : bus_bytes;
    src_base  = half ? NARROW : 0;
    ext_off   = req_off + OW'(src_base);
    lane_base = bus16 ? (int'(ext_off) % NARROW) : int'(ext_off);
  end

  logic [OW-1:0] lane_src [LANES];

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic              en;
    int                src;
    logic [BYTE_W-1:0] wb;

    always_comb begin
      en  = (i >= lane_base) && (i < lane_base + cyc_bytes);
      src = en ? (i - lane_base + src_base) : 0;
      wb  = en ? wdata[src*BYTE_W +: BYTE_W] : '0;
    end

    assign lane_en[i]                    = en;
    assign lane_src[i]                   = OW'(src);
    assign lane_wdata[i*BYTE_W +: BYTE_W] = wb;
  end

  // Read gather: each active lane lands on its source byte position
  always_comb begin
    gathered = '0;
    for (int i = 0; i < LANES; i++) begin
      if (lane_en[i]) gathered[int'(lane_src[i])*BYTE_W +: BYTE_W] = lane_rdata[i*BYTE_W +: BYTE_W];
    end
  end
endmodule

// File: rtl/lsteer_seq.sv
module lsteer_seq
  import lsteer_pkg::*;
#(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int DW = LANES * BYTE_W,
  localparam int OW = $clog2(LANES)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [1:0]    req_size,
  input  logic [OW-1:0] req_off,
  input  logic [DW-1:0] req_wdata,
  input  logic          req_misaligned,
  input  logic          req_split,
  input  logic          ext_ack,
  input  logic [DW-1:0] gathered,
  output logic          busy,
  output logic          half,
  output logic          cap_write,
  output logic [1:0]    cap_size,
  output logic [OW-1:0] cap_off,
  output logic [DW-1:0] cap_wdata,
  output logic          rsp_done,
  output logic          rsp_err,
  output logic [DW-1:0] rsp_rdata
);
  seq_state_e st_q, st_d;
  logic       half_q, half_d;
  logic       split_q;
  logic       done_q, done_d;
  logic       err_q, err_d;
  logic [DW-1:0] acc_q, acc_d;
  logic [DW-1:0] rdata_q, rdata_d;
  logic       accept, load_req, load_rdata;

  assign accept = (st_q == ST_IDLE) && req_valid;
  assign load_req = accept && !req_misaligned;

  // Next-state logic
  always_comb begin
    st_d       = st_q;
    half_d     = half_q;
    acc_d      = acc_q;
    rdata_d    = rdata_q;
    done_d     = 1'b0;
    err_d      = 1'b0;
    load_rdata = 1'b0;
    unique case (st_q)
      ST_IDLE: begin
        if (accept) begin
          if (req_misaligned) begin
            err_d = 1'b1;
          end else begin
            st_d   = ST_ACCESS;
            half_d = 1'b0;
            acc_d  = '0;
          end
        end
      end
      ST_ACCESS: begin
        if (ext_ack) begin
          if (split_q && !half_q) begin
            half_d = 1'b1;
            acc_d  = acc_q | gathered;
          end else begin
            st_d       = ST_IDLE;
            half_d     = 1'b0;
            done_d     = 1'b1;
            load_rdata = 1'b1;
            rdata_d    = acc_q | gathered;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  // Control registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      half_q <= 1'b0;
      done_q <= 1'b0;
      err_q  <= 1'b0;
      acc_q  <= '0;
    end else begin
      st_q   <= st_d;
      half_q <= half_d;
      done_q <= done_d;
      err_q  <= err_d;
      acc_q  <= acc_d;
    end
  end

  // Request capture, enabled on acceptance only
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cap_write <= 1'b0;
      cap_size  <= '0;
      cap_off   <= '0;
      cap_wdata <= '0;
      split_q   <= 1'b0;
    end else if (load_req) begin
      cap_write <= req_write;
      cap_size  <= req_size;
      cap_off   <= req_off;
      cap_wdata <= req_wdata;
      split_q   <= req_split;
    end
  end

  // Result register, enabled on the final acknowledge
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          rdata_q <= '0;
    else if (load_rdata) rdata_q <= rdata_d;
  end

  assign busy      = (st_q == ST_ACCESS);
  assign half      = half_q;
  assign rsp_done  = done_q;
  assign rsp_err   = err_q;
  assign rsp_rdata = rdata_q;

  p_err_no_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_err |-> !busy);
  p_one_response_r12: assert property (@(posedge clk) disable iff (!rst_n)
    !(rsp_done && rsp_err));
  p_done_after_ack_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |-> ($past(ext_ack) && $past(busy)));
  p_half_only_split_r6: assert property (@(posedge clk) disable iff (!rst_n)
    half_q |-> (busy && split_q));
endmodule

// File: rtl/ext_lane_steer.sv
module ext_lane_steer #(
  parameter int LANES  = 4,
  parameter int BYTE_W = 8,
  localparam int DW     = LANES * BYTE_W,
  localparam int OW     = $clog2(LANES),
  localparam int NARROW = LANES / 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             bus16,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic             req_write,
  input  logic [1:0]       req_size,
  input  logic [OW-1:0]    req_offset,
  input  logic [DW-1:0]    req_wdata,
  output logic             rsp_done,
  output logic             rsp_err,
  output logic [DW-1:0]    rsp_rdata,
  output logic             ext_req,
  input  logic             ext_ack,
  output logic             ext_write,
  output logic [OW-1:0]    ext_offset,
  output logic [LANES-1:0] ext_strb_n,
  output logic [DW-1:0]    ext_wdata,
  input  logic [DW-1:0]    ext_rdata
);
  logic             rst_sync_n;
  logic             misaligned, split;
  logic             busy, half, cap_write;
  logic [1:0]       cap_size;
  logic [OW-1:0]    cap_off, ext_off;
  logic [DW-1:0]    cap_wdata, lane_wdata, gathered;
  logic [LANES-1:0] lane_en;

  lsteer_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n)
  );

  lsteer_check #(.LANES(LANES)) u_check (
    .bus16(bus16), .size(req_size), .off(req_offset),
    .misaligned(misaligned), .split(split)
  );

  lsteer_seq #(.LANES(LANES), .BYTE_W(BYTE_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .req_valid(req_valid), .req_write(req_write), .req_size(req_size),
    .req_off(req_offset), .req_wdata(req_wdata),
    .req_misaligned(misaligned), .req_split(split),
    .ext_ack(ext_ack), .gathered(gathered),
    .busy(busy), .half(half), .cap_write(cap_write), .cap_size(cap_size),
    .cap_off(cap_off), .cap_wdata(cap_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata)
  );

  lsteer_lanes #(.LANES(LANES), .BYTE_W(BYTE_W)) u_lanes (
    .bus16(bus16), .size(cap_size), .req_off(cap_off), .half(half),
    .wdata(cap_wdata), .lane_rdata(ext_rdata),
    .ext_off(ext_off), .lane_en(lane_en),
    .lane_wdata(lane_wdata), .gathered(gathered)
  );

  assign req_ready  = !busy;
  assign ext_req    = busy;
  assign ext_write  = busy && cap_write;
  assign ext_offset = busy ? ext_off : '0;
  assign ext_strb_n = busy ? ~lane_en : '1;
  assign ext_wdata  = (busy && cap_write) ? lane_wdata : '0;

  p_strb_idle_r10: assert property (@(posedge clk) disable iff (!rst_sync_n)
    !ext_req |-> (&ext_strb_n));
  p_narrow_upper_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ext_req && bus16) |-> (&ext_strb_n[LANES-1:NARROW]));
  p_some_lane_r1: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ext_req |-> !(&ext_strb_n));
  p_busy_not_ready_r11: assert property (@(posedge clk) disable iff (!rst_sync_n)
    ext_req |-> !req_ready);
  p_hold_until_ack_r12: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (ext_req && !ext_ack) |=> (ext_req && $stable(ext_offset) && $stable(ext_strb_n) && $stable(ext_wdata)));
endmodule

// File: tb/tb_ext_lane_steer.sv
module tb_ext_lane_steer;
  localparam int CLK_PERIOD = 10;

  logic        clk, rst_n, bus16;
  logic        req_valid, req_ready, req_write;
  logic [1:0]  req_size, req_offset;
  logic [31:0] req_wdata, rsp_rdata;
  logic        rsp_done, rsp_err;
  logic        ext_req, ext_ack, ext_write;
  logic [1:0]  ext_offset;
  logic [3:0]  ext_strb_n;
  logic [31:0] ext_wdata, ext_rdata;

  int nchk = 0;
  int nerr = 0;
  logic [31:0] seed = 32'h1234_5678;

  ext_lane_steer dut (
    .clk(clk), .rst_n(rst_n), .bus16(bus16),
    .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
    .req_size(req_size), .req_offset(req_offset), .req_wdata(req_wdata),
    .rsp_done(rsp_done), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
    .ext_req(ext_req), .ext_ack(ext_ack), .ext_write(ext_write),
    .ext_offset(ext_offset), .ext_strb_n(ext_strb_n),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  function automatic logic [31:0] nxt();
    seed = seed ^ (seed << 13);
    seed = seed ^ (seed >> 17);
    seed = seed ^ (seed << 5);
    return seed;
  endfunction

  task automatic chk(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
    nchk++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic string lane_tag(input bit b16, input int sz);
    if (!b16) return (sz == 0) ? "R1" : (sz == 1) ? "R2" : "R3";
    return (sz == 0) ? "R4" : (sz == 1) ? "R5" : "R6";
  endfunction

  task automatic run_req(input bit b16, input bit wr, input int sz, input int off, input bit poke);
    logic [31:0] wd, ew, erd;
    logic [3:0]  em;
    logic [1:0]  eo;
    logic [31:0] rdv [2];
    int ncyc, waits;
    bit mis;
    string tg;
    wd  = nxt();
    mis = (sz == 3) || (sz == 1 && off[0]) || (sz == 2 && off != 0);
    @(negedge clk);
    bus16 = b16; req_valid = 1'b1; req_write = wr;
    req_size = 2'(sz); req_offset = 2'(off); req_wdata = wd;
    @(negedge clk);
    req_valid = 1'b0;
    if (mis) begin
      chk("R9", "rsp_err", {31'b0, rsp_err}, 32'd1);
      chk("R9", "ext_req", {31'b0, ext_req}, 32'd0);
      chk("R9", "strobes", {28'b0, ext_strb_n}, 32'hF);
      @(negedge clk);
      chk("R9", "err pulse end", {31'b0, rsp_err}, 32'd0);
      chk("R9", "no cycle later", {31'b0, ext_req}, 32'd0);
      return;
    end
    ncyc = (b16 && sz == 2) ? 2 : 1;
    tg   = lane_tag(b16, sz);
    for (int h = 0; h < ncyc; h++) begin
      if (!b16) begin
        eo = 2'(off);
        case (sz)
          0: begin em = 4'b0001 << off; ew = {24'b0, wd[7:0]} << (8*off); end
          1: begin em = 4'b0011 << off; ew = {16'b0, wd[15:0]} << (8*off); end
          default: begin em = 4'hF; ew = wd; end
        endcase
      end else begin
        case (sz)
          0: begin eo = 2'(off); em = 4'b0001 << off[0]; ew = {24'b0, wd[7:0]} << (8*off[0]); end
          1: begin eo = 2'(off); em = 4'b0011; ew = {16'b0, wd[15:0]}; end
          default: begin eo = 2'(2*h); em = 4'b0011; ew = {16'b0, (h == 1) ? wd[31:16] : wd[15:0]}; end
        endcase
      end
      if (!wr) ew = '0;
      waits = poke ? 1 + int'(nxt() % 2) : int'(nxt() % 3);
      for (int w = 0; w <= waits; w++) begin
        chk("R12", "ext_req held", {31'b0, ext_req}, 32'd1);
        chk(tg, "ext_offset", {30'b0, ext_offset}, {30'b0, eo});
        chk(tg, "strobes", {28'b0, ext_strb_n}, {28'b0, ~em});
        chk(wr ? tg : "R10", "ext_wdata", ext_wdata, ew);
        chk(tg, "ext_write", {31'b0, ext_write}, {31'b0, wr});
        chk("R11", "ready while busy", {31'b0, req_ready}, 32'd0);
        chk("R12", "no early done", {31'b0, rsp_done}, 32'd0);
        if (w == waits) begin
          rdv[h] = nxt(); ext_rdata = rdv[h]; ext_ack = 1'b1;
        end else if (poke && w == 0) begin
          req_valid = 1'b1; req_write = 1'b1; req_size = 2'd0; req_offset = 2'd1; req_wdata = nxt();
        end
        @(negedge clk);
        ext_ack = 1'b0; req_valid = 1'b0; ext_rdata = nxt();
      end
    end
    chk("R12", "rsp_done", {31'b0, rsp_done}, 32'd1);
    chk("R12", "no err", {31'b0, rsp_err}, 32'd0);
    if (!wr) begin
      if (!b16) begin
        case (sz)
          0: erd = (rdv[0] >> (8*off)) & 32'hFF;
          1: erd = (off == 2) ? {16'b0, rdv[0][31:16]} : {16'b0, rdv[0][15:0]};
          default: erd = rdv[0];
        endcase
      end else begin
        case (sz)
          0: erd = off[0] ? {24'b0, rdv[0][15:8]} : {24'b0, rdv[0][7:0]};
          1: erd = {16'b0, rdv[0][15:0]};
          default: erd = {rdv[1][15:0], rdv[0][15:0]};
        endcase
      end
      chk((b16 && sz == 2) ? "R8" : "R7", "rsp_rdata", rsp_rdata, erd);
    end
    @(negedge clk);
    chk("R12", "done one cycle", {31'b0, rsp_done}, 32'd0);
    chk("R10", "idle strobes", {28'b0, ext_strb_n}, 32'hF);
    chk("R10", "idle wdata", ext_wdata, 32'd0);
    if (poke) begin
      @(negedge clk);
      chk("R11", "busy request ignored", {31'b0, ext_req}, 32'd0);
      chk("R11", "busy request no err", {31'b0, rsp_err}, 32'd0);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL watchdog expired actual=running expected=finished");
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end

  initial begin
    rst_n = 1'b0; bus16 = 1'b0; req_valid = 1'b0; req_write = 1'b0;
    req_size = '0; req_offset = '0; req_wdata = '0; ext_ack = 1'b0; ext_rdata = '0;
    repeat (3) @(negedge clk);
    chk("R13", "ready in reset", {31'b0, req_ready}, 32'd1);
    chk("R13", "ext_req in reset", {31'b0, ext_req}, 32'd0);
    chk("R13", "strobes in reset", {28'b0, ext_strb_n}, 32'hF);
    chk("R13", "done/err in reset", {30'b0, rsp_done, rsp_err}, 32'd0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    chk("R13", "ready after reset", {31'b0, req_ready}, 32'd1);
    for (int b = 0; b < 2; b++)
      for (int wr = 0; wr < 2; wr++)
        for (int sz = 0; sz < 4; sz++)
          for (int off = 0; off < 4; off++)
            run_req(b[0], wr[0], sz, off, 1'b0);
    run_req(1'b1, 1'b1, 2, 0, 1'b1);
    run_req(1'b1, 1'b0, 2, 0, 1'b1);
    run_req(1'b0, 1'b0, 1, 2, 1'b1);
    run_req(1'b1, 1'b0, 0, 3, 1'b1);
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  end
endmodule